// File: doc/BRIEF.md
# Link-Layer Frame Transmit Sequencer

This block sits between a transport-side word source and a serial link's primitive stream. When the source offers a frame, the block asks the far end for the right to transmit. Once the far end grants it, the block marks the start of the frame and passes the payload words out one by one. It then appends a CRC word and an end marker, and waits for the far end to report whether the frame arrived intact. That verdict is returned to the transport side as a one-cycle pulse.

Outgoing symbols are a 4-bit primitive code (`tx_prim`) with a data-valid flag (`tx_dvalid`) and a 32-bit word (`tx_data`). Incoming primitives from the far end arrive as the same 4-bit code on `rx_prim`. Codes: 0 idle, 1 transmitter-ready, 2 receiver-ready, 3 receive-in-progress, 4 start-of-frame, 5 data word, 6 hold, 7 hold-acknowledge, 8 end-of-frame, 9 wait-for-termination, 10 receive-good, 11 receive-bad.

The payload arrives on a valid/ready stream. A word moves on a cycle in which `s_valid` and `s_ready` are both high. `s_last` marks the final word of a frame. A raised `s_valid` means a frame is pending, and the first word must already be presented with it. Once `s_valid` is high it stays high, with `s_data` and `s_last` held, until the word is taken. `s_ready` depends on `s_valid` and `rx_prim` in the same cycle.

Top module: `frame_tx_seq`

## Requirements
- R1: After reset, and whenever no frame is pending, the block sends code 0 with `tx_dvalid`, `s_ready`, `done_ok`, `done_err` and `len_err` all low.
- R2: A pending frame makes the block send code 1 every cycle, and at least two code-1 symbols go out directly before code 4.
- R3: Code 4 is sent only in the cycle after code 2 was received. The first payload word taken after that is output as code 5 with `tx_dvalid` high and `tx_data` equal to that word.
- R4: While the far end sends code 3, payload words keep flowing unchanged.
- R5: In the payload phase, when no word is offered and the far end is not holding, the block sends code 6 and takes no word.
- R6: While code 6 is received during the payload or CRC phase, the block sends code 7, holds `s_ready` low and does not advance.
- R7: After the last word, the block sends one code-5 word holding a CRC-32 (polynomial 0x04C11DB7, seed 0x52325032, no reflection, no final inversion, fed from bit 31 down to bit 0 of each word), and then code 8.
- R8: After code 8, the block sends code 9 until code 10 or 11 arrives. On the next cycle it raises `done_ok` (for 10) or `done_err` (for 11) for exactly one cycle and returns to its idle behaviour.
- R9: With `IS_HOST`=1, a code 1 received during arbitration is ignored, and the block keeps sending code 1.
- R10: With `IS_HOST`=0, a code 1 received during arbitration makes the block send code 2 from the next cycle until the far end stops sending code 1. The block then goes idle for one cycle and requests again.
- R11: A frame is cut at `MAX_WORDS` (default 2049) words. If that word is taken without `s_last`, the CRC and end marker follow at once, and `len_err` stays high until the next code 4.
- R12: `s_ready` is high only in cycles in which a code-5 payload word is output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Payload word offered / frame pending |
| s_ready | output | 1 | Payload word taken this cycle |
| s_data | input | 32 | Payload word |
| s_last | input | 1 | Final word of the frame |
| rx_prim | input | 4 | Primitive code received from the far end |
| tx_prim | output | 4 | Primitive code sent this cycle |
| tx_dvalid | output | 1 | `tx_data` carries a payload or CRC word |
| tx_data | output | 32 | Outgoing word, zero when `tx_dvalid` is low |
| done_ok | output | 1 | One-cycle pulse: far end reported good reception |
| done_err | output | 1 | One-cycle pulse: far end reported bad reception |
| len_err | output | 1 | Frame exceeded the length cap |

## Verification
The assertions assume a source that obeys the stream rules: a raised `s_valid` is never dropped before its word is taken, and `s_data` and `s_last` stay stable while it waits. They also assume that `rx_prim` carries only the listed codes and that the far end eventually answers code 9 with a verdict. The bench source changes `s_valid` only after a transfer or while it is low, and always presents the word at the current index. The far-end model draws from the defined codes: holds and receive-in-progress during the payload, a short random wait before the verdict, and a collision window before granting receiver-ready.

// File: rtl/link_pkg.sv
package link_pkg;
  localparam int WORD_W = 32;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED = 32'h52325032;

  typedef enum logic [3:0] {
    PR_IDLE  = 4'd0,
    PR_XRDY  = 4'd1,
    PR_RRDY  = 4'd2,
    PR_RIP   = 4'd3,
    PR_SOF   = 4'd4,
    PR_DATA  = 4'd5,
    PR_HOLD  = 4'd6,
    PR_HOLDA = 4'd7,
    PR_EOF   = 4'd8,
    PR_WTRM  = 4'd9,
    PR_ROK   = 4'd10,
    PR_RERR  = 4'd11
  } prim_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARB, ST_YIELD, ST_SOF, ST_PAY, ST_CRC, ST_EOF, ST_WTRM
  } tx_state_e;

  // One whole-word CRC update, most significant bit first.
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/lnk_crc32.sv
module lnk_crc32
  import link_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              en,
  input  logic [WORD_W-1:0] din,
  output logic [31:0]       crc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= CRC_SEED;
    else if (clear) crc_q <= CRC_SEED;
    else if (en)    crc_q <= crc_step(crc_q, din);
  end

  // R7: every frame's CRC starts from the seed
  assert_crc_seed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc_q == CRC_SEED));
endmodule

// File: rtl/lnk_len_guard.sv
module lnk_len_guard #(
  parameter int MAX_WORDS = 2049,
  localparam int CW = $clog2(MAX_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          at_cap
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign at_cap = (cnt == CW'(MAX_WORDS - 1));

  // R11: the payload count never passes the cap
  assert_len_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX_WORDS));
endmodule

// File: rtl/lnk_tx_fsm.sv
module lnk_tx_fsm
  import link_pkg::*;
#(
  parameter bit IS_HOST  = 1'b1,
  parameter int MIN_XRDY = 2,
  parameter int CW       = 12,
  localparam int XW = $clog2(MIN_XRDY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  input  logic          s_last,
  input  prim_e         rx_prim,
  input  logic          at_cap,
  input  logic [CW-1:0] cnt,
  output prim_e         tx_prim,
  output logic          tx_dvalid,
  output logic          sel_crc,
  output logic          s_ready,
  output logic          acc,
  output logic          frame_clr,
  output logic          done_ok,
  output logic          done_err,
  output logic          len_err
);
  tx_state_e st, nxt;
  logic [XW-1:0] xr_cnt;
  logic yield_en;

  generate
    if (IS_HOST) begin : g_host
      assign yield_en = 1'b0;
    end else begin : g_dev
      assign yield_en = 1'b1;
    end
  endgenerate

  always_comb begin
    nxt       = st;
    tx_prim   = PR_IDLE;
    tx_dvalid = 1'b0;
    sel_crc   = 1'b0;
    s_ready   = 1'b0;
    acc       = 1'b0;
    frame_clr = 1'b0;
    unique case (st)
      ST_IDLE: if (s_valid) nxt = ST_ARB;
      ST_ARB: begin
        tx_prim = PR_XRDY;
        if (yield_en && rx_prim == PR_XRDY) nxt = ST_YIELD;
        else if (rx_prim == PR_RRDY && xr_cnt >= XW'(MIN_XRDY - 1)) nxt = ST_SOF;
      end
      ST_YIELD: begin
        tx_prim = PR_RRDY;
        if (rx_prim != PR_XRDY) nxt = ST_IDLE;
      end
      ST_SOF: begin
        tx_prim   = PR_SOF;
        frame_clr = 1'b1;
        nxt       = ST_PAY;
      end
      ST_PAY: begin
        if (rx_prim == PR_HOLD) tx_prim = PR_HOLDA;
        else if (s_valid) begin
          tx_prim   = PR_DATA;
          tx_dvalid = 1'b1;
          s_ready   = 1'b1;
          acc       = 1'b1;
          if (s_last || at_cap) nxt = ST_CRC;
        end else tx_prim = PR_HOLD;
      end
      ST_CRC: begin
        if (rx_prim == PR_HOLD) tx_prim = PR_HOLDA;
        else begin
          tx_prim   = PR_DATA;
          tx_dvalid = 1'b1;
          sel_crc   = 1'b1;
          nxt       = ST_EOF;
        end
      end
      ST_EOF: begin
        tx_prim = PR_EOF;
        nxt     = ST_WTRM;
      end
      ST_WTRM: begin
        tx_prim = PR_WTRM;
        if (rx_prim == PR_ROK || rx_prim == PR_RERR) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      xr_cnt   <= '0;
      done_ok  <= 1'b0;
      done_err <= 1'b0;
      len_err  <= 1'b0;
    end else begin
      st <= nxt;
      if (st != ST_ARB) xr_cnt <= '0;
      else if (xr_cnt != XW'(MIN_XRDY)) xr_cnt <= xr_cnt + 1'b1;
      done_ok  <= (st == ST_WTRM) && (rx_prim == PR_ROK);
      done_err <= (st == ST_WTRM) && (rx_prim == PR_RERR);
      if (st == ST_SOF) len_err <= 1'b0;
      else if (acc && at_cap && !s_last) len_err <= 1'b1;
    end
  end

  // R2: two requests directly precede the start marker
  assert_two_xrdy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_prim == PR_SOF) |-> ($past(tx_prim) == PR_XRDY && $past(tx_prim, 2) == PR_XRDY));
  // R3: start marker only after a grant
  assert_sof_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_prim == PR_SOF) |-> ($past(rx_prim) == PR_RRDY));
  // R6: a far-end hold freezes the payload count
  assert_hold_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PAY && rx_prim == PR_HOLD) |=> $stable(cnt));
  // R7: end marker directly follows the CRC word
  assert_eof_after_crc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_prim == PR_EOF) |-> ($past(tx_dvalid) && $past(sel_crc)));
  // R8: verdict pulses match the received answer and never coincide
  assert_ok_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> ($past(rx_prim) == PR_ROK && !done_err));
  assert_err_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> ($past(rx_prim) == PR_RERR));
  // R10: a yielding device answers with receiver-ready while the far end requests
  assert_yield_rrdy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_YIELD && rx_prim == PR_XRDY) |=> (tx_prim == PR_RRDY));
endmodule

// File: rtl/frame_tx_seq.sv
module frame_tx_seq
  import link_pkg::*;
#(
  parameter bit IS_HOST   = 1'b1,
  parameter int MAX_WORDS = 2049,
  parameter int MIN_XRDY  = 2,
  localparam int CW = $clog2(MAX_WORDS + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [31:0] s_data,
  input  logic        s_last,
  input  logic [3:0]  rx_prim,
  output logic [3:0]  tx_prim,
  output logic        tx_dvalid,
  output logic [31:0] tx_data,
  output logic        done_ok,
  output logic        done_err,
  output logic        len_err
);
  prim_e         rx_e, tx_e;
  logic          sel_crc, acc, frame_clr, at_cap;
  logic [CW-1:0] cnt;
  logic [31:0]   crc_q;

  assign rx_e = prim_e'(rx_prim);

  lnk_tx_fsm #(.IS_HOST(IS_HOST), .MIN_XRDY(MIN_XRDY), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_last(s_last),
    .rx_prim(rx_e), .at_cap(at_cap), .cnt(cnt), .tx_prim(tx_e),
    .tx_dvalid(tx_dvalid), .sel_crc(sel_crc), .s_ready(s_ready), .acc(acc),
    .frame_clr(frame_clr), .done_ok(done_ok), .done_err(done_err), .len_err(len_err)
  );

  lnk_len_guard #(.MAX_WORDS(MAX_WORDS)) u_guard (
    .clk(clk), .rst_n(rst_n), .clr(frame_clr), .inc(acc), .cnt(cnt), .at_cap(at_cap)
  );

  lnk_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .clear(frame_clr), .en(acc), .din(s_data), .crc_q(crc_q)
  );

  assign tx_prim = tx_e;
  assign tx_data = !tx_dvalid ? 32'h0 : (sel_crc ? crc_q : s_data);

  // R12: the source is drained only while a payload word goes out
  assert_ready_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (tx_dvalid && tx_prim == PR_DATA && !sel_crc));
endmodule

// File: tb/frame_tx_seq_bench.sv
module frame_tx_seq_bench;
  import link_pkg::*;
  localparam int MAXW = 2049;

  logic clk = 1'b0;
  logic rst_n;
  logic s_valid, s_last, s_ready, tx_dvalid, done_ok, done_err, len_err;
  logic [31:0] s_data, tx_data;
  logic [3:0] rx_prim, tx_prim;
  logic d_valid, d_ready, d_dvalid, d_ok, d_err, d_len;
  logic [3:0] d_rx, d_tx;
  logic [31:0] d_data;
  int checks = 0, errors = 0;
  logic [31:0] words [0:2099];

  always #4 clk = ~clk;

  frame_tx_seq #(.IS_HOST(1'b1), .MAX_WORDS(MAXW)) u_frame_tx_seq (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .rx_prim(rx_prim), .tx_prim(tx_prim), .tx_dvalid(tx_dvalid),
    .tx_data(tx_data), .done_ok(done_ok), .done_err(done_err), .len_err(len_err));

  frame_tx_seq #(.IS_HOST(1'b0), .MAX_WORDS(MAXW)) u_frame_tx_seq_dev (
    .clk(clk), .rst_n(rst_n), .s_valid(d_valid), .s_ready(d_ready), .s_data(32'h0),
    .s_last(1'b0), .rx_prim(d_rx), .tx_prim(d_tx), .tx_dvalid(d_dvalid),
    .tx_data(d_data), .done_ok(d_ok), .done_err(d_err), .len_err(d_len));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r = c;
    for (int b = 31; b >= 0; b--) begin
      logic fb = r[31] ^ d[b];
      r = r << 1;
      if (fb) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  task automatic run_frame(input int n, input int hold_pct, input int gap_pct,
                           input bit ok_ans, input int collide);
    int idx, xcount, phase, wtrm_left, cyc, lim, grant_at;
    bit sv, took;
    logic [3:0] rx, prev_rx;
    logic [31:0] ecrc;
    idx = 0; xcount = 0; phase = 0; cyc = 0; sv = 1'b1;
    rx = PR_IDLE; prev_rx = PR_IDLE; ecrc = 32'h52325032;
    lim = (n > MAXW) ? MAXW : n;
    for (int i = 0; i < n; i++) words[i] = $urandom;
    for (int i = 0; i < lim; i++) ecrc = ref_crc(ecrc, words[i]);
    wtrm_left = int'($urandom % 4);
    grant_at = collide + int'($urandom % 3);
    if (collide > 0) rx = PR_XRDY;
    while (phase != 6 && cyc < 10000) begin
      @(posedge clk); #1;
      s_valid = sv;
      s_data  = (idx < n) ? words[idx] : 32'h0;
      s_last  = (idx == n - 1);
      rx_prim = rx;
      @(negedge clk);
      cyc++;
      took = 1'b0;
      case (phase)
        0: begin
          if (tx_prim == PR_XRDY) begin
            if (rx == PR_XRDY) chk(1'b1, "R9", 32'(tx_prim), 32'(PR_XRDY));
            xcount++;
          end else if (tx_prim == PR_SOF) begin
            chk(xcount >= 2, "R2 request count", xcount, 2);
            chk(prev_rx == PR_RRDY, "R3 grant before start", 32'(prev_rx), 32'(PR_RRDY));
            phase = 1;
          end else if (xcount > 0)
            chk(1'b0, (rx == PR_XRDY) ? "R9 host kept requesting" : "R2 request",
                32'(tx_prim), 32'(PR_XRDY));
        end
        1: begin
          if (rx == PR_HOLD)
            chk(tx_prim == PR_HOLDA && !s_ready, "R6 hold in payload", 32'(tx_prim), 32'(PR_HOLDA));
          else if (sv) begin
            chk(tx_prim == PR_DATA && tx_dvalid && s_ready, "R12 data handshake",
                32'(tx_prim), 32'(PR_DATA));
            chk(tx_data == words[idx], (rx == PR_RIP) ? "R4 word under R_IP" : "R3 payload word",
                tx_data, words[idx]);
            took = 1'b1;
            idx++;
            if (idx == lim) phase = 2;
          end else
            chk(tx_prim == PR_HOLD && !s_ready, "R5 starved", 32'(tx_prim), 32'(PR_HOLD));
        end
        2: begin
          if (rx == PR_HOLD)
            chk(tx_prim == PR_HOLDA && !tx_dvalid, "R6 hold at crc", 32'(tx_prim), 32'(PR_HOLDA));
          else begin
            chk(tx_dvalid && tx_data == ecrc, "R7 crc word", tx_data, ecrc);
            phase = 3;
          end
        end
        3: begin
          chk(tx_prim == PR_EOF, "R7 end marker", 32'(tx_prim), 32'(PR_EOF));
          phase = 4;
        end
        4: begin
          chk(tx_prim == PR_WTRM, "R8 waiting", 32'(tx_prim), 32'(PR_WTRM));
          if (rx == PR_ROK || rx == PR_RERR) phase = 5;
        end
        5: begin
          chk(done_ok == ok_ans && done_err == !ok_ans, "R8 verdict pulse",
              {30'h0, done_ok, done_err}, {30'h0, ok_ans, !ok_ans});
          chk(tx_prim == PR_IDLE && !tx_dvalid, "R8 back to idle", 32'(tx_prim), 32'(PR_IDLE));
          chk(len_err == (n > MAXW), "R11 length flag", 32'(len_err), 32'(n > MAXW));
          phase = 6;
        end
        default: ;
      endcase
      prev_rx = rx;
      case (phase)
        0: rx = (xcount < collide) ? PR_XRDY : ((xcount >= grant_at) ? PR_RRDY : PR_IDLE);
        1: begin
          rx = (int'($urandom % 100) < hold_pct) ? PR_HOLD : PR_RIP;
          if (took || !sv) sv = (int'($urandom % 100) >= gap_pct);
        end
        2: begin
          rx = (int'($urandom % 100) < hold_pct) ? PR_HOLD : PR_RIP;
          sv = 1'b0;
        end
        3: begin rx = PR_RIP; sv = 1'b0; end
        4: begin
          if (wtrm_left == 0) rx = ok_ans ? PR_ROK : PR_RERR;
          else begin wtrm_left--; rx = PR_RIP; end
        end
        default: rx = PR_IDLE;
      endcase
    end
    chk(phase == 6, "R8 frame completed", phase, 6);
    @(posedge clk); #1;
    s_valid = 1'b0; rx_prim = PR_IDLE;
    @(negedge clk);
    chk(!done_ok && !done_err, "R8 single-cycle pulse", {30'h0, done_ok, done_err}, 32'h0);
  endtask

  task automatic dev_step(input logic [3:0] rxv, input logic [3:0] exp, input string req);
    @(posedge clk); #1;
    d_rx = rxv;
    @(negedge clk);
    chk(d_tx == exp && !d_ready, req, 32'(d_tx), 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired before completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A7A1D03));
    rst_n = 1'b0; s_valid = 1'b0; s_last = 1'b0; s_data = '0; rx_prim = PR_IDLE;
    d_valid = 1'b0; d_rx = PR_IDLE;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(tx_prim == PR_IDLE && !tx_dvalid && !s_ready && !done_ok && !done_err && !len_err,
        "R1 reset state", 32'(tx_prim), 32'(PR_IDLE));
    repeat (3) @(negedge clk);
    chk(tx_prim == PR_IDLE && d_tx == PR_IDLE, "R1 idle without frame", 32'(tx_prim), 32'(PR_IDLE));

    // directed: single word, clean link
    run_frame(1, 0, 0, 1'b1, 0);
    // directed: host collision with receive-bad answer
    run_frame(4, 0, 0, 1'b0, 3);
    // random frames
    for (int k = 0; k < 8; k++)
      run_frame(1 + int'($urandom % 40), int'($urandom % 30), int'($urandom % 40),
                1'(int'($urandom % 2)), (k % 3 == 0) ? 1 + int'($urandom % 3) : 0);
    // over-length frame hits the cap
    run_frame(2060, 5, 10, 1'b1, 0);
    // a normal frame afterwards clears the length flag
    run_frame(3, 10, 10, 1'b1, 0);

    // device-side collision (R10)
    @(posedge clk); #1 d_valid = 1'b1;
    @(negedge clk);
    dev_step(PR_IDLE, PR_XRDY, "R10 device requests");
    dev_step(PR_XRDY, PR_XRDY, "R10 device still requesting");
    for (int j = 0; j < 3; j++) dev_step(PR_XRDY, PR_RRDY, "R10 device yields");
    dev_step(PR_IDLE, PR_RRDY, "R10 yield until far end stops");
    dev_step(PR_IDLE, PR_IDLE, "R10 idle gap");
    dev_step(PR_IDLE, PR_XRDY, "R10 re-request");
    dev_step(PR_RRDY, PR_XRDY, "R10 second request");
    dev_step(PR_RRDY, PR_SOF, "R10 start after retry");
    @(posedge clk); #1 d_valid = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule